// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor and a slower main memory and holds recently used data in a two-way set-associative store. Addresses are 32 bits wide and lines are 32 bytes. The processor issues word reads, word writes and line invalidations through a ready/valid request port. Each request gets exactly one response pulse, and a read response carries the requested word. The memory side moves whole lines. A read channel fetches a line on a miss. A write channel drains evicted dirty lines.

Writes use a write-back, write-allocate policy. A store updates only the cached copy and marks the line dirty. When a dirty line is displaced, it is appended to a four-entry queue that writes to memory on its own. The refill that caused the eviction therefore proceeds without waiting for that write to finish. A miss to a line that is still queued is served from the queue instead of memory.

Top module: `wbc_top`

## Requirements
- R1: The request address splits into byte-in-word bits 1..0 (must be zero), word select bits 4..2, set index bits 10..5 and tag bits 31..11. A lookup hits only when one way of the indexed set is valid and its stored tag equals the tag bits. A hit reads no line from memory.
- R2: After reset every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0. The first access to any line misses.
- R3: A read miss raises `mem_rd_req` with the line-aligned address (bits 4..0 zero) and holds it until `mem_rd_valid`. It then installs the line and answers with the word picked by bits 4..2. Word w occupies line bits 32*w+31..32*w.
- R4: A write hit changes only the cached word, marks the line dirty and produces no memory write.
- R5: Further writes to a line that is already dirty cause no memory traffic of any kind.
- R6: A write miss first fills the line from memory. The store is then merged into that line, the line is marked dirty, and the other words keep their memory values.
- R7: A dirty line that is displaced is written to memory with its own line address and its latest contents. A clean line that is displaced is dropped without a memory write.
- R8: The victim is an invalid way of the set if one exists (way 0 first). Otherwise it is the least recently used way, where every hit and every fill counts as a use.
- R9: An invalidate request clears the valid bit of a matching line. Its cached contents, even if dirty, are discarded without a memory write, and the next access to it misses.
- R10: When the write-back queue already holds 4 lines and another dirty victim must be queued, the request stalls with no response until a queued line drains.
- R11: A read miss whose line is still waiting in the write-back queue takes the newest queued copy and issues no memory read.
- R12: Queued lines are written to memory oldest first. One line leaves the queue per `mem_wr_done` pulse, and the head line and address stay unchanged while they wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = word write, 0 = word read |
| cpu_req_inv | input | 1 | 1 = invalidate the addressed line (overrides we) |
| cpu_req_addr | input | 32 | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read word (or the merged word for a write) |
| mem_rd_req | output | 1 | Line fetch request, held until served |
| mem_rd_addr | output | 32 | Line-aligned fetch address |
| mem_rd_valid | input | 1 | Fetch data pulse |
| mem_rd_line | input | 256 | Fetched line |
| mem_wr_req | output | 1 | Queue head waiting to be written |
| mem_wr_addr | output | 32 | Line-aligned write address of the queue head |
| mem_wr_line | output | 256 | Line data of the queue head |
| mem_wr_done | input | 1 | Memory finished writing the head line |

## Verification
The bench targets replacement order and the write-back queue. In one set it touches one line again before a third line arrives. A design that replaced in fill order instead of use order would then refetch the wrong line. It holds the memory write channel so that the queue fills. A controller that ignored the full condition would drop or overwrite a dirty line, and the drained sequence would show a missing or misordered address. It also reads back a line whose dirty copy is still queued. Going to memory there would return stale data and raise the read count. Invalidating a dirty line and then reading it exposes any design that writes the discarded data back or keeps the line valid.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL_CHK,
    ST_FILL_WAIT
  } wbc_state_e;
endpackage

// File: rtl/wbc_line_ram.sv
module wbc_line_ram #(
  parameter int IDX_W  = 6,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [LINE_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_line;
    if (rd_en) rd_line <= store[rd_idx];
  end
endmodule

// File: rtl/wbc_wbuf.sv
module wbc_wbuf #(
  parameter int DEPTH   = 4,
  parameter int LADDR_W = 27,
  parameter int LINE_W  = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [LADDR_W-1:0] push_addr,
  input  logic [LINE_W-1:0]  push_line,
  output logic               full,
  output logic               head_valid,
  output logic [LADDR_W-1:0] head_addr,
  output logic [LINE_W-1:0]  head_line,
  input  logic               pop,
  input  logic [LADDR_W-1:0] find_addr,
  output logic               find_hit,
  output logic [LINE_W-1:0]  find_line
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [LADDR_W-1:0] addr_q [DEPTH];
  logic [LINE_W-1:0]  line_q [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   cnt;
  logic               do_push, do_pop;

  assign full       = (cnt == CNT_W'(DEPTH));
  assign head_valid = (cnt != '0);
  assign head_addr  = addr_q[rd_ptr];
  assign head_line  = line_q[rd_ptr];
  assign do_push    = push && !full;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (do_push) begin
      addr_q[wr_ptr] <= push_addr;
      line_q[wr_ptr] <= push_line;
    end
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // Scan from oldest to newest; the newest matching copy wins.
  always_comb begin
    find_hit  = 1'b0;
    find_line = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] slot;
      slot = rd_ptr + PTR_W'(k);
      if ((CNT_W'(k) < cnt) && (addr_q[slot] == find_addr)) begin
        find_hit  = 1'b1;
        find_line = line_q[slot];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);  // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);  // R12
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !pop) |=> (head_valid && $stable(head_addr) && $stable(head_line)));  // R12
endmodule

// File: rtl/wbc_top.sv
module wbc_top #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 64,
  parameter int WB_DEPTH   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_req_valid,
  output logic                      cpu_req_ready,
  input  logic                      cpu_req_we,
  input  logic                      cpu_req_inv,
  input  logic [ADDR_W-1:0]         cpu_req_addr,
  input  logic [WORD_W-1:0]         cpu_req_wdata,
  output logic                      cpu_rsp_valid,
  output logic [WORD_W-1:0]         cpu_rsp_rdata,
  output logic                      mem_rd_req,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic                      mem_rd_valid,
  input  logic [LINE_BYTES*8-1:0]   mem_rd_line,
  output logic                      mem_wr_req,
  output logic [ADDR_W-1:0]         mem_wr_addr,
  output logic [LINE_BYTES*8-1:0]   mem_wr_line,
  input  logic                      mem_wr_done
);
  import wbc_pkg::*;

  localparam int LINE_W  = LINE_BYTES * 8;
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int BYTE_W  = $clog2(WORD_W / 8);
  localparam int WSEL_W  = OFF_W - BYTE_W;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int WAYS    = 2;

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] s,
                                                 input logic [WORD_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = ln;
    r[s*WORD_W +: WORD_W] = d;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] s);
    return ln[s*WORD_W +: WORD_W];
  endfunction

  // Request latch
  wbc_state_e          st_q;
  logic                rq_we, rq_inv;
  logic [TAG_W-1:0]    rq_tag;
  logic [IDX_W-1:0]    rq_idx;
  logic [WSEL_W-1:0]   rq_wsel;
  logic [WORD_W-1:0]   rq_wdata;
  logic                vict_q;

  // Line state
  logic [TAG_W-1:0]    tag_q   [WAYS][SETS];
  logic [SETS-1:0]     valid_q [WAYS];
  logic [SETS-1:0]     dirty_q [WAYS];
  logic [SETS-1:0]     lru_q;   // way to replace next

  // Data ways
  logic [LINE_W-1:0]   way_line [WAYS];
  logic [WAYS-1:0]     ram_we;
  logic [LINE_W-1:0]   ram_wline;
  logic                ram_rd;

  // Lookup
  logic [WAYS-1:0]     hit_w;
  logic                hit_any, hit_way, vict_c;

  // Write-back queue
  logic                wb_push, wb_full, wb_head_valid, wb_find_hit;
  logic [LADDR_W-1:0]  wb_head_addr;
  logic [LINE_W-1:0]   wb_find_line;

  // Fill
  logic                fill_go;
  logic [LINE_W-1:0]   fill_src, fill_line;

  assign cpu_req_ready = (st_q == ST_IDLE);
  assign ram_rd        = cpu_req_valid && (st_q == ST_IDLE);

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_w[w] = valid_q[w][rq_idx] && (tag_q[w][rq_idx] == rq_tag);
      wbc_line_ram #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_ram (
        .clk     (clk),
        .rd_en   (ram_rd),
        .rd_idx  (cpu_req_addr[OFF_W +: IDX_W]),
        .rd_line (way_line[w]),
        .wr_en   (ram_we[w]),
        .wr_idx  (rq_idx),
        .wr_line (ram_wline)
      );
    end
  endgenerate

  assign hit_any = |hit_w;
  assign hit_way = hit_w[1];

  always_comb begin
    if (!valid_q[0][rq_idx])      vict_c = 1'b0;
    else if (!valid_q[1][rq_idx]) vict_c = 1'b1;
    else                          vict_c = lru_q[rq_idx];
  end

  assign wb_push = (st_q == ST_EVICT) && !wb_full;

  wbc_wbuf #(.DEPTH(WB_DEPTH), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_wbuf (
    .clk        (clk),
    .rst        (rst),
    .push       (wb_push),
    .push_addr  ({tag_q[vict_q][rq_idx], rq_idx}),
    .push_line  (way_line[vict_q]),
    .full       (wb_full),
    .head_valid (wb_head_valid),
    .head_addr  (wb_head_addr),
    .head_line  (mem_wr_line),
    .pop        (mem_wr_done),
    .find_addr  ({rq_tag, rq_idx}),
    .find_hit   (wb_find_hit),
    .find_line  (wb_find_line)
  );

  assign mem_wr_req  = wb_head_valid;
  assign mem_wr_addr = {wb_head_addr, {OFF_W{1'b0}}};

  assign fill_go   = ((st_q == ST_FILL_CHK) && wb_find_hit) ||
                     ((st_q == ST_FILL_WAIT) && mem_rd_valid);
  assign fill_src  = (st_q == ST_FILL_CHK) ? wb_find_line : mem_rd_line;
  assign fill_line = rq_we ? put_word(fill_src, rq_wsel, rq_wdata) : fill_src;

  always_comb begin
    ram_we    = '0;
    ram_wline = fill_line;
    if (st_q == ST_LOOK && !rq_inv && hit_any && rq_we) begin
      ram_we[hit_way] = 1'b1;
      ram_wline       = put_word(way_line[hit_way], rq_wsel, rq_wdata);
    end else if (fill_go) begin
      ram_we[vict_q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) tag_q[vict_q][rq_idx] <= rq_tag;
    if (rst) begin
      st_q          <= ST_IDLE;
      valid_q[0]    <= '0;
      valid_q[1]    <= '0;
      dirty_q[0]    <= '0;
      dirty_q[1]    <= '0;
      lru_q         <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      mem_rd_req    <= 1'b0;
      mem_rd_addr   <= '0;
      vict_q        <= 1'b0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            rq_we    <= cpu_req_we;
            rq_inv   <= cpu_req_inv;
            rq_tag   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
            rq_idx   <= cpu_req_addr[OFF_W +: IDX_W];
            rq_wsel  <= cpu_req_addr[BYTE_W +: WSEL_W];
            rq_wdata <= cpu_req_wdata;
            st_q     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (rq_inv) begin
            if (hit_any) begin
              valid_q[hit_way][rq_idx] <= 1'b0;
              dirty_q[hit_way][rq_idx] <= 1'b0;
            end
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= '0;
            st_q          <= ST_IDLE;
          end else if (hit_any) begin
            lru_q[rq_idx] <= ~hit_way;
            if (rq_we) begin
              dirty_q[hit_way][rq_idx] <= 1'b1;
              cpu_rsp_rdata <= rq_wdata;
            end else begin
              cpu_rsp_rdata <= get_word(way_line[hit_way], rq_wsel);
            end
            cpu_rsp_valid <= 1'b1;
            st_q          <= ST_IDLE;
          end else begin
            vict_q <= vict_c;
            st_q   <= (valid_q[vict_c][rq_idx] && dirty_q[vict_c][rq_idx]) ? ST_EVICT : ST_FILL_CHK;
          end
        end
        ST_EVICT: begin
          if (!wb_full) begin
            dirty_q[vict_q][rq_idx] <= 1'b0;
            st_q                    <= ST_FILL_CHK;
          end
        end
        ST_FILL_CHK: begin
          if (!wb_find_hit) begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= {rq_tag, rq_idx, {OFF_W{1'b0}}};
            st_q        <= ST_FILL_WAIT;
          end
        end
        ST_FILL_WAIT: begin
          if (mem_rd_valid) mem_rd_req <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (fill_go) begin
        valid_q[vict_q][rq_idx] <= 1'b1;
        dirty_q[vict_q][rq_idx] <= rq_we;
        lru_q[rq_idx]           <= ~vict_q;
        cpu_rsp_valid           <= 1'b1;
        cpu_rsp_rdata           <= get_word(fill_line, rq_wsel);
        st_q                    <= ST_IDLE;
      end
    end
  end

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |-> (cpu_req_addr[BYTE_W-1:0] == '0));  // R1
  AST_HIT_NO_MEMREAD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOOK && !rq_inv && hit_any) |=> (!mem_rd_req && st_q == ST_IDLE && cpu_rsp_valid));  // R1
  AST_RD_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));  // R3
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FILL_WAIT && mem_rd_valid) |=> valid_q[$past(vict_q)][$past(rq_idx)]);  // R3
  AST_WRHIT_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOOK && !rq_inv && rq_we && hit_any) |=> dirty_q[$past(hit_way)][$past(rq_idx)]);  // R4
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOOK && rq_inv && hit_any) |=> !valid_q[$past(hit_way)][$past(rq_idx)]);  // R9
  AST_EVICT_WAITS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EVICT && wb_full) |=> (st_q == ST_EVICT && !cpu_rsp_valid));  // R10
endmodule

// File: tb/tb_wbc_top.sv
`timescale 1ns/1ps
module tb_wbc_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req_valid = 1'b0, cpu_req_we = 1'b0, cpu_req_inv = 1'b0;
  logic [31:0]  cpu_req_addr = '0, cpu_req_wdata = '0;
  logic         cpu_req_ready, cpu_rsp_valid;
  logic [31:0]  cpu_rsp_rdata;
  logic         mem_rd_req, mem_rd_valid = 1'b0;
  logic [31:0]  mem_rd_addr, mem_wr_addr;
  logic [255:0] mem_rd_line = '0, mem_wr_line;
  logic         mem_wr_req, mem_wr_done = 1'b0;

  int checks = 0, failures = 0;
  int n_rd = 0, n_wr = 0;
  bit wr_hold = 1'b0;
  bit finished = 1'b0;
  logic [255:0] mem_model [int unsigned];
  logic [31:0]  wlog_addr [64];
  logic [31:0]  wlog_w0   [64];

  always #2 clk = ~clk;

  wbc_top dut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_inv(cpu_req_inv),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_line(mem_wr_line), .mem_wr_done(mem_wr_done)
  );

  function automatic logic [31:0] mk(input int tag, input int idx, input int w);
    return {tag[20:0], idx[5:0], w[2:0], 2'b00};
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[28:5], 5'b0, a[4:2]};
  endfunction

  function automatic logic [255:0] line_of(input logic [31:0] a);
    logic [255:0] r;
    int unsigned key;
    key = {5'b0, a[31:5]};
    if (mem_model.exists(key)) return mem_model[key];
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = pat({a[31:5], w[2:0], 2'b00});
    return r;
  endfunction

  // Memory model: responds at falling edges.
  initial begin
    int rd_cnt = 0, wr_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) mem_rd_valid <= 1'b0;
      else if (mem_rd_req) begin
        if (rd_cnt == 3) begin
          mem_rd_valid <= 1'b1;
          mem_rd_line  <= line_of(mem_rd_addr);
          n_rd++;
          rd_cnt = 0;
        end else rd_cnt++;
      end
      if (mem_wr_done) mem_wr_done <= 1'b0;
      else if (mem_wr_req && !wr_hold) begin
        if (wr_cnt == 2) begin
          mem_wr_done <= 1'b1;
          mem_model[{5'b0, mem_wr_addr[31:5]}] = mem_wr_line;
          if (n_wr < 64) begin
            wlog_addr[n_wr] = mem_wr_addr;
            wlog_w0[n_wr]   = mem_wr_line[31:0];
          end
          n_wr++;
          wr_cnt = 0;
        end else wr_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_issue(input bit we, input bit inv, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_inv = inv;
    cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic cpu_wait(input int limit, output logic [31:0] rd, output bit got);
    got = 1'b0; rd = '0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cpu_rsp_valid) begin got = 1'b1; rd = cpu_rsp_rdata; break; end
    end
  endtask

  task automatic cpu_op(input bit we, input bit inv, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
    bit got;
    cpu_issue(we, inv, a, d);
    cpu_wait(500, rd, got);
    check(got, "R3 response", 32'(got), 32'd1);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 400 && mem_wr_req; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cpu_req_ready == 1'b1, "R2 ready", 32'(cpu_req_ready), 32'd1);
    check({cpu_rsp_valid, mem_rd_req, mem_wr_req} == 3'b000, "R2 idle outputs",
          32'({cpu_rsp_valid, mem_rd_req, mem_wr_req}), 32'd0);
  endtask

  task automatic t_read_fill();
    logic [31:0] rd; int r0;
    r0 = n_rd;
    cpu_op(0, 0, mk(5, 1, 3), 0, rd);
    check(rd == pat(mk(5, 1, 3)), "R3 miss data", rd, pat(mk(5, 1, 3)));
    check(n_rd == r0 + 1, "R2 first access misses", n_rd, r0 + 1);
    cpu_op(0, 0, mk(5, 1, 6), 0, rd);
    check(rd == pat(mk(5, 1, 6)) && n_rd == r0 + 1, "R1 hit same line", rd, pat(mk(5, 1, 6)));
    cpu_op(0, 0, mk(6, 1, 3), 0, rd);
    check(n_rd == r0 + 2, "R1 other tag misses", n_rd, r0 + 2);
    check(rd == pat(mk(6, 1, 3)), "R3 second line data", rd, pat(mk(6, 1, 3)));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int r0, w0;
    cpu_op(0, 0, mk(7, 4, 0), 0, rd);
    r0 = n_rd; w0 = n_wr;
    cpu_op(1, 0, mk(7, 4, 2), 32'h1111_2222, rd);
    cpu_op(1, 0, mk(7, 4, 2), 32'h3333_4444, rd);
    cpu_op(1, 0, mk(7, 4, 5), 32'h5555_6666, rd);
    repeat (10) @(negedge clk);
    check(n_wr == w0 && !mem_wr_req, "R4 no memory write", n_wr, w0);
    check(n_rd == r0, "R5 no traffic on dirty rewrite", n_rd, r0);
    cpu_op(0, 0, mk(7, 4, 2), 0, rd);
    check(rd == 32'h3333_4444, "R4 latest write", rd, 32'h3333_4444);
    cpu_op(0, 0, mk(7, 4, 5), 0, rd);
    check(rd == 32'h5555_6666, "R5 second word", rd, 32'h5555_6666);
  endtask

  task automatic t_write_alloc();
    logic [31:0] rd; int r0;
    r0 = n_rd;
    cpu_op(1, 0, mk(9, 5, 1), 32'hCAFE_0001, rd);
    check(n_rd == r0 + 1, "R6 fill on write miss", n_rd, r0 + 1);
    cpu_op(0, 0, mk(9, 5, 1), 0, rd);
    check(rd == 32'hCAFE_0001, "R6 merged word", rd, 32'hCAFE_0001);
    cpu_op(0, 0, mk(9, 5, 0), 0, rd);
    check(rd == pat(mk(9, 5, 0)) && n_rd == r0 + 1, "R6 other word kept", rd, pat(mk(9, 5, 0)));
  endtask

  task automatic t_lru();
    logic [31:0] rd; int r0, w0;
    w0 = n_wr;
    cpu_op(0, 0, mk(1, 6, 0), 0, rd);
    cpu_op(0, 0, mk(2, 6, 0), 0, rd);
    cpu_op(0, 0, mk(1, 6, 1), 0, rd);
    cpu_op(0, 0, mk(3, 6, 0), 0, rd);
    r0 = n_rd;
    cpu_op(0, 0, mk(1, 6, 2), 0, rd);
    check(n_rd == r0, "R8 recently used line kept", n_rd, r0);
    cpu_op(0, 0, mk(2, 6, 2), 0, rd);
    check(n_rd == r0 + 1, "R8 LRU line evicted", n_rd, r0 + 1);
    repeat (10) @(negedge clk);
    check(n_wr == w0, "R7 clean eviction no write", n_wr, w0);
  endtask

  task automatic t_inval();
    logic [31:0] rd; int r0, w0;
    w0 = n_wr;
    cpu_op(1, 0, mk(4, 7, 3), 32'hDEAD_BEEF, rd);
    cpu_op(0, 1, mk(4, 7, 0), 0, rd);
    r0 = n_rd;
    cpu_op(0, 0, mk(4, 7, 3), 0, rd);
    check(n_rd == r0 + 1, "R9 access after invalidate misses", n_rd, r0 + 1);
    check(rd == pat(mk(4, 7, 3)), "R9 dirty data discarded", rd, pat(mk(4, 7, 3)));
    repeat (10) @(negedge clk);
    check(n_wr == w0, "R9 no write-back", n_wr, w0);
  endtask

  task automatic t_forward();
    logic [31:0] rd; int r0, w0;
    w0 = n_wr;
    wr_hold = 1'b1;
    cpu_op(1, 0, mk(1, 8, 4), 32'hF00D_0001, rd);
    cpu_op(1, 0, mk(2, 8, 4), 32'hF00D_0002, rd);
    cpu_op(1, 0, mk(3, 8, 4), 32'hF00D_0003, rd);
    r0 = n_rd;
    cpu_op(0, 0, mk(1, 8, 4), 0, rd);
    check(rd == 32'hF00D_0001, "R11 data from queue", rd, 32'hF00D_0001);
    check(n_rd == r0, "R11 no memory read", n_rd, r0);
    wr_hold = 1'b0;
    wait_drain();
    check(n_wr == w0 + 2, "R7 two dirty lines written", n_wr, w0 + 2);
    check(line_of(mk(1, 8, 0))[4*32 +: 32] == 32'hF00D_0001, "R7 written contents",
          line_of(mk(1, 8, 0))[4*32 +: 32], 32'hF00D_0001);
  endtask

  task automatic t_full();
    logic [31:0] rd; bit got; int w0;
    wait_drain();
    w0 = n_wr;
    wr_hold = 1'b1;
    for (int t = 1; t <= 6; t++) cpu_op(1, 0, mk(t, 9, 0), 32'hA000 + t, rd);
    cpu_issue(1, 0, mk(7, 9, 0), 32'hA007);
    cpu_wait(40, rd, got);
    check(!got, "R10 stall while queue full", 32'(got), 32'd0);
    check(mem_wr_req == 1'b1, "R10 queue pending", 32'(mem_wr_req), 32'd1);
    wr_hold = 1'b0;
    cpu_wait(500, rd, got);
    check(got, "R10 resumes after drain", 32'(got), 32'd1);
    wait_drain();
    check(n_wr == w0 + 5, "R12 five lines drained", n_wr, w0 + 5);
    for (int k = 0; k < 5; k++) begin
      if (w0 + k < 64) begin
        check(wlog_addr[w0+k] == mk(k + 1, 9, 0), "R12 drain order", wlog_addr[w0+k], mk(k + 1, 9, 0));
        check(wlog_w0[w0+k] == 32'hA000 + k + 1, "R7 evicted data", wlog_w0[w0+k], 32'hA000 + k + 1);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_fill();
    t_write_hit();
    t_write_alloc();
    t_lru();
    t_inval();
    t_forward();
    t_full();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule